// File: doc/BRIEF.md
# Segment Translation and Protection Unit

This block turns a two-part logical address, a segment number plus a byte offset inside that segment, into a physical address. It keeps a small segment table in internal registers. Each entry holds a starting physical address (the base), a segment length (the limit), a valid flag and three permission bits for read, write and execute. A separate length register sets how many segments are legal.

For every request the unit checks four things: the segment number against the length register, the entry's valid flag, the requested access type against the entry's permissions, and the offset against the limit. It then returns either base plus offset or a trap with an encoded cause. The result is registered, one cycle after the request. Table entries and the length register are loaded through a single configuration write port, one write per cycle.

Top module: `seg_xlate`

## Requirements
- R1: After reset every entry is invalid, the length register is 0, and rsp_valid, rsp_trap, rsp_cause and rsp_pa are all 0. A request made right after reset therefore traps with the length cause.
- R2: A request sampled with req_valid high at a clock edge gives rsp_valid high after that same edge, with the result for that request. A cycle with no request gives rsp_valid low after its edge. Requests may be issued back to back.
- R3: A segment number greater than or equal to the length register traps with cause 1. A segment number one below the length register is legal.
- R4: A legal segment whose entry has its valid flag at 0 traps with cause 2.
- R5: Permission bit 0 allows read, bit 1 allows write and bit 2 allows execute. The access code is 0 for read, 1 for write, 2 for execute, and 3 is never allowed. An access that is not allowed traps with cause 3.
- R6: An offset greater than or equal to the entry's limit traps with cause 4. The offset limit-1 is legal.
- R7: An access that passes every check gives rsp_trap 0, rsp_cause 0 and rsp_pa equal to base plus offset, modulo 2^PA_W.
- R8: When more than one check fails, the reported cause is the first of this order: length (1), invalid (2), permission (3), limit (4).
- R9: A configuration write with cfg_sel 0 loads entry cfg_idx, and one with cfg_sel 1 loads the length register. The write takes effect for requests in later cycles. A request in the same cycle as the write sees the old contents.
- R10: rsp_pa is 0 whenever rsp_trap is 1 or rsp_valid is 0. rsp_trap is never 1 while rsp_valid is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Translation request strobe |
| req_seg | input | SEG_W | Segment number of the logical address |
| req_off | input | OFF_W | Offset within the segment |
| req_acc | input | 2 | Access type: 0 read, 1 write, 2 execute, 3 reserved |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 1 | 0 writes a table entry, 1 writes the length register |
| cfg_idx | input | SEG_W | Entry index for an entry write |
| cfg_base | input | PA_W | Base physical address for an entry write |
| cfg_limit | input | OFF_W+1 | Segment length for an entry write |
| cfg_valid | input | 1 | Valid flag for an entry write |
| cfg_perm | input | 3 | Permissions for an entry write: bit0 read, bit1 write, bit2 execute |
| cfg_len | input | SEG_W+1 | New length register value |
| rsp_valid | output | 1 | Result present for the request of the previous cycle |
| rsp_trap | output | 1 | Request trapped |
| rsp_cause | output | 3 | 0 none, 1 length, 2 invalid, 3 permission, 4 limit |
| rsp_pa | output | PA_W | Translated physical address, 0 on a trap |

## Verification
On every cycle the assertions check the one-cycle response timing, that a segment at or above the length register always traps with the length cause, that a trap always carries a non-zero cause while a clean result carries none, and that the physical address is 0 on a trap or when idle. The per-entry behaviour can only be shown by the bench's scenarios. That covers each permission bit, the limit boundary at limit-1 and limit, the order in which overlapping faults are reported, address wrap-around, and a request that meets a configuration write in the same cycle. The bench checks these against a model table that it keeps in step with its own writes.

// File: rtl/seg_xlate_pkg.sv
package seg_xlate_pkg;

   typedef enum logic [1:0] {
      ACC_READ  = 2'd0,
      ACC_WRITE = 2'd1,
      ACC_EXEC  = 2'd2,
      ACC_RSVD  = 2'd3
   } acc_e;

   typedef enum logic [2:0] {
      CAUSE_NONE    = 3'd0,
      CAUSE_LENGTH  = 3'd1,
      CAUSE_INVALID = 3'd2,
      CAUSE_PERM    = 3'd3,
      CAUSE_LIMIT   = 3'd4
   } cause_e;

   localparam int PERM_BIT_R = 0;
   localparam int PERM_BIT_W = 1;
   localparam int PERM_BIT_X = 2;

endpackage

// File: rtl/seg_xlate_table.sv
module seg_xlate_table #(
   parameter int SEG_W = 3,
   parameter int PA_W  = 16,
   parameter int LIM_W = 13,
   parameter int LEN_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_we,
   input  logic             cfg_sel,
   input  logic [SEG_W-1:0] cfg_idx,
   input  logic [PA_W-1:0]  cfg_base,
   input  logic [LIM_W-1:0] cfg_limit,
   input  logic             cfg_valid,
   input  logic [2:0]       cfg_perm,
   input  logic [LEN_W-1:0] cfg_len,
   input  logic [SEG_W-1:0] rd_idx,
   output logic [PA_W-1:0]  rd_base,
   output logic [LIM_W-1:0] rd_limit,
   output logic             rd_valid,
   output logic [2:0]       rd_perm,
   output logic [LEN_W-1:0] len_q
);
   localparam int NSEG = 1 << SEG_W;

   logic [PA_W-1:0]  base_q  [NSEG];
   logic [LIM_W-1:0] limit_q [NSEG];
   logic [2:0]       perm_q  [NSEG];
   logic [NSEG-1:0]  valid_q;
   logic [NSEG-1:0]  ent_we;

   // per-entry write decode
   for (genvar g = 0; g < NSEG; g++) begin : g_we
      assign ent_we[g] = cfg_we && !cfg_sel && (cfg_idx == SEG_W'(g));
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         valid_q <= '0;
         for (int i = 0; i < NSEG; i++) begin
            base_q[i]  <= '0;
            limit_q[i] <= '0;
            perm_q[i]  <= '0;
         end
      end else begin
         for (int i = 0; i < NSEG; i++) begin
            if (ent_we[i]) begin
               base_q[i]  <= cfg_base;
               limit_q[i] <= cfg_limit;
               perm_q[i]  <= cfg_perm;
               valid_q[i] <= cfg_valid;
            end
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)                 len_q <= '0;
      else if (cfg_we && cfg_sel) len_q <= cfg_len;
   end

   assign rd_base  = base_q[rd_idx];
   assign rd_limit = limit_q[rd_idx];
   assign rd_perm  = perm_q[rd_idx];
   assign rd_valid = valid_q[rd_idx];

endmodule

// File: rtl/seg_xlate_check.sv
module seg_xlate_check
   import seg_xlate_pkg::*;
#(
   parameter int SEG_W = 3,
   parameter int OFF_W = 12,
   parameter int PA_W  = 16,
   parameter int LIM_W = 13,
   parameter int LEN_W = 4
) (
   input  logic [SEG_W-1:0] seg,
   input  logic [OFF_W-1:0] off,
   input  logic [1:0]       acc,
   input  logic [LEN_W-1:0] len,
   input  logic [PA_W-1:0]  e_base,
   input  logic [LIM_W-1:0] e_limit,
   input  logic             e_valid,
   input  logic [2:0]       e_perm,
   output logic [2:0]       cause,
   output logic [PA_W-1:0]  pa
);
   logic len_bad;
   logic lim_bad;
   logic perm_ok;

   assign len_bad = LEN_W'(seg) >= len;
   assign lim_bad = LIM_W'(off) >= e_limit;

   always_comb begin
      unique case (acc_e'(acc))
         ACC_READ:  perm_ok = e_perm[PERM_BIT_R];
         ACC_WRITE: perm_ok = e_perm[PERM_BIT_W];
         ACC_EXEC:  perm_ok = e_perm[PERM_BIT_X];
         default:   perm_ok = 1'b0;
      endcase
   end

   // fault priority: length, invalid, permission, limit
   always_comb begin
      if (len_bad)       cause = CAUSE_LENGTH;
      else if (!e_valid) cause = CAUSE_INVALID;
      else if (!perm_ok) cause = CAUSE_PERM;
      else if (lim_bad)  cause = CAUSE_LIMIT;
      else               cause = CAUSE_NONE;
   end

   assign pa = e_base + PA_W'(off);

endmodule

// File: rtl/seg_xlate.sv
module seg_xlate
   import seg_xlate_pkg::*;
#(
   parameter int SEG_W = 3,
   parameter int OFF_W = 12,
   parameter int PA_W  = 16
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               req_valid,
   input  logic [SEG_W-1:0]   req_seg,
   input  logic [OFF_W-1:0]   req_off,
   input  logic [1:0]         req_acc,
   input  logic               cfg_we,
   input  logic               cfg_sel,
   input  logic [SEG_W-1:0]   cfg_idx,
   input  logic [PA_W-1:0]    cfg_base,
   input  logic [OFF_W:0]     cfg_limit,
   input  logic               cfg_valid,
   input  logic [2:0]         cfg_perm,
   input  logic [SEG_W:0]     cfg_len,
   output logic               rsp_valid,
   output logic               rsp_trap,
   output logic [2:0]         rsp_cause,
   output logic [PA_W-1:0]    rsp_pa
);
   localparam int LIM_W = OFF_W + 1;
   localparam int LEN_W = SEG_W + 1;

   if (SEG_W < 1 || SEG_W > 8) begin : g_bad_seg
      $error("seg_xlate: SEG_W must be 1..8");
   end
   if (OFF_W < 1 || PA_W < OFF_W) begin : g_bad_off
      $error("seg_xlate: need 1 <= OFF_W <= PA_W");
   end

   logic [PA_W-1:0]  e_base;
   logic [LIM_W-1:0] e_limit;
   logic             e_valid;
   logic [2:0]       e_perm;
   logic [LEN_W-1:0] len_q;
   logic [2:0]       nxt_cause;
   logic [PA_W-1:0]  nxt_pa;

   seg_xlate_table #(
      .SEG_W(SEG_W), .PA_W(PA_W), .LIM_W(LIM_W), .LEN_W(LEN_W)
   ) u_table (
      .clk      (clk),
      .rst_n    (rst_n),
      .cfg_we   (cfg_we),
      .cfg_sel  (cfg_sel),
      .cfg_idx  (cfg_idx),
      .cfg_base (cfg_base),
      .cfg_limit(cfg_limit),
      .cfg_valid(cfg_valid),
      .cfg_perm (cfg_perm),
      .cfg_len  (cfg_len),
      .rd_idx   (req_seg),
      .rd_base  (e_base),
      .rd_limit (e_limit),
      .rd_valid (e_valid),
      .rd_perm  (e_perm),
      .len_q    (len_q)
   );

   seg_xlate_check #(
      .SEG_W(SEG_W), .OFF_W(OFF_W), .PA_W(PA_W), .LIM_W(LIM_W), .LEN_W(LEN_W)
   ) u_check (
      .seg    (req_seg),
      .off    (req_off),
      .acc    (req_acc),
      .len    (len_q),
      .e_base (e_base),
      .e_limit(e_limit),
      .e_valid(e_valid),
      .e_perm (e_perm),
      .cause  (nxt_cause),
      .pa     (nxt_pa)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rsp_valid <= 1'b0;
         rsp_trap  <= 1'b0;
         rsp_cause <= CAUSE_NONE;
         rsp_pa    <= '0;
      end else begin
         rsp_valid <= req_valid;
         rsp_trap  <= req_valid && (nxt_cause != CAUSE_NONE);
         rsp_cause <= req_valid ? nxt_cause : CAUSE_NONE;
         rsp_pa    <= (req_valid && nxt_cause == CAUSE_NONE) ? nxt_pa : '0;
      end
   end

endmodule

// File: rtl/seg_xlate_chk.sv
module seg_xlate_chk #(
   parameter int SEG_W = 3,
   parameter int PA_W  = 16,
   parameter int LEN_W = 4
) (
   input logic             clk,
   input logic             rst_n,
   input logic             req_valid,
   input logic [SEG_W-1:0] req_seg,
   input logic             rsp_valid,
   input logic             rsp_trap,
   input logic [2:0]       rsp_cause,
   input logic [PA_W-1:0]  rsp_pa,
   input logic [LEN_W-1:0] len_q
);
   AST_RSP_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> rsp_valid);                                           // R2
   AST_IDLE_NO_RSP: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> !rsp_valid);                                         // R2
   AST_LENGTH_TRAP: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && (LEN_W'(req_seg) >= len_q)) |=> (rsp_trap && rsp_cause == 3'd1)); // R3
   AST_TRAP_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_trap |-> (rsp_cause != 3'd0 && rsp_cause <= 3'd4));            // R8
   AST_CLEAN_NO_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && !rsp_trap) |-> rsp_cause == 3'd0);                    // R7
   AST_PA_ZERO_ON_TRAP: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_trap || !rsp_valid) |-> rsp_pa == '0);                         // R10
   AST_NO_TRAP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !rsp_valid |-> !rsp_trap);                                          // R10
endmodule

bind seg_xlate seg_xlate_chk #(
   .SEG_W(SEG_W), .PA_W(PA_W), .LEN_W(LEN_W)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .req_valid(req_valid),
   .req_seg  (req_seg),
   .rsp_valid(rsp_valid),
   .rsp_trap (rsp_trap),
   .rsp_cause(rsp_cause),
   .rsp_pa   (rsp_pa),
   .len_q    (len_q)
);

// File: tb/seg_xlate_tb.sv
`timescale 1ns/1ps
module seg_xlate_tb;
   localparam int SEG_W = 3;
   localparam int OFF_W = 12;
   localparam int PA_W  = 16;
   localparam int NSEG  = 1 << SEG_W;

   logic               clk = 1'b0;
   logic               rst_n = 1'b0;
   logic               req_valid = 1'b0;
   logic [SEG_W-1:0]   req_seg = '0;
   logic [OFF_W-1:0]   req_off = '0;
   logic [1:0]         req_acc = '0;
   logic               cfg_we = 1'b0;
   logic               cfg_sel = 1'b0;
   logic [SEG_W-1:0]   cfg_idx = '0;
   logic [PA_W-1:0]    cfg_base = '0;
   logic [OFF_W:0]     cfg_limit = '0;
   logic               cfg_valid = 1'b0;
   logic [2:0]         cfg_perm = '0;
   logic [SEG_W:0]     cfg_len = '0;
   logic               rsp_valid;
   logic               rsp_trap;
   logic [2:0]         rsp_cause;
   logic [PA_W-1:0]    rsp_pa;

   int checks = 0;
   int errors = 0;

   // bench model of the table
   logic [PA_W-1:0] m_base  [NSEG];
   logic [OFF_W:0]  m_limit [NSEG];
   logic            m_valid [NSEG];
   logic [2:0]      m_perm  [NSEG];
   int              m_len;

   always #10 clk = ~clk;

   seg_xlate #(.SEG_W(SEG_W), .OFF_W(OFF_W), .PA_W(PA_W)) u_dut (.*);

   task automatic chk(string tag, longint act, longint exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   function automatic int exp_cause(int seg, int off, int acc);
      bit ok;
      if (seg >= m_len) return 1;
      if (!m_valid[seg]) return 2;
      case (acc)
         0: ok = m_perm[seg][0];
         1: ok = m_perm[seg][1];
         2: ok = m_perm[seg][2];
         default: ok = 1'b0;
      endcase
      if (!ok) return 3;
      if (off >= int'(m_limit[seg])) return 4;
      return 0;
   endfunction

   function automatic int exp_pa(int seg, int off);
      return (int'(m_base[seg]) + off) & ((1 << PA_W) - 1);
   endfunction

   task automatic set_entry(int idx, int base, int lim, bit v, int perm);
      cfg_we = 1'b1; cfg_sel = 1'b0; cfg_idx = SEG_W'(idx);
      cfg_base = PA_W'(base); cfg_limit = (OFF_W+1)'(lim);
      cfg_valid = v; cfg_perm = 3'(perm);
      @(negedge clk);
      cfg_we = 1'b0;
      m_base[idx] = PA_W'(base); m_limit[idx] = (OFF_W+1)'(lim);
      m_valid[idx] = v; m_perm[idx] = 3'(perm);
   endtask

   task automatic set_len(int len);
      cfg_we = 1'b1; cfg_sel = 1'b1; cfg_len = (SEG_W+1)'(len);
      @(negedge clk);
      cfg_we = 1'b0;
      m_len = len;
   endtask

   // issue one request at a falling edge, check it one edge later
   task automatic send(int seg, int off, int acc, string tag);
      int ec, ep;
      ec = exp_cause(seg, off, acc);
      ep = (ec == 0) ? exp_pa(seg, off) : 0;
      req_valid = 1'b1; req_seg = SEG_W'(seg);
      req_off = OFF_W'(off); req_acc = 2'(acc);
      @(negedge clk);
      req_valid = 1'b0;
      chk({tag, " valid"}, rsp_valid, 1);
      chk({tag, " cause"}, rsp_cause, ec);
      chk({tag, " trap"},  rsp_trap, (ec != 0));
      chk({tag, " pa"},    rsp_pa, ep);
   endtask

   initial begin
      #(20 * 150000);
      errors++;
      $display("FAIL watchdog actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      int ec, sv_seg;
      void'($urandom(32'd4242));
      for (int i = 0; i < NSEG; i++) begin
         m_base[i] = '0; m_limit[i] = '0; m_valid[i] = 1'b0; m_perm[i] = '0;
      end
      m_len = 0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1: reset state
      chk("R1 rsp_valid", rsp_valid, 0);
      chk("R1 rsp_trap",  rsp_trap, 0);
      chk("R1 rsp_cause", rsp_cause, 0);
      chk("R1 rsp_pa",    rsp_pa, 0);
      send(0, 0, 0, "R1 R3 len0");
      // R2: idle cycle
      @(negedge clk);
      chk("R2 idle valid", rsp_valid, 0);
      chk("R10 idle trap", rsp_trap, 0);
      chk("R10 idle pa", rsp_pa, 0);

      set_len(8);
      set_entry(0, 16'h1000, 13'h100, 1'b1, 3'b001);
      send(0, 12'h010, 0, "R7 read ok");
      send(0, 12'h010, 1, "R5 write denied");
      send(0, 12'h010, 2, "R5 exec denied");
      send(0, 12'h010, 3, "R5 rsvd denied");
      send(0, 12'h0FF, 0, "R6 limit-1 ok");
      send(0, 12'h100, 0, "R6 at limit");
      send(0, 12'h200, 1, "R8 perm before limit");
      set_entry(1, 16'h2000, 13'h010, 1'b0, 3'b000);
      send(1, 12'hFFF, 3, "R4 R8 invalid first");
      set_entry(2, 16'h3000, 13'h040, 1'b1, 3'b110);
      send(2, 12'h03F, 1, "R5 write ok");
      send(2, 12'h001, 2, "R5 exec ok");
      send(2, 12'h001, 0, "R5 read denied");
      set_len(2);
      send(1, 12'h000, 0, "R3 seg len-1 reaches entry");
      send(2, 12'h001, 1, "R3 seg at len");
      set_len(8);
      set_entry(3, 16'hFFF0, 13'h1000, 1'b1, 3'b111);
      send(3, 12'h020, 0, "R7 wrap");
      send(3, 12'hFFF, 2, "R6 full size ok");

      // R9: write and request in same cycle use the old table
      sv_seg = 3;
      ec = exp_cause(sv_seg, 12'h010, 0);
      cfg_we = 1'b1; cfg_sel = 1'b0; cfg_idx = 3'd3; cfg_base = 16'h4000;
      cfg_limit = 13'h008; cfg_valid = 1'b1; cfg_perm = 3'b111;
      req_valid = 1'b1; req_seg = 3'd3; req_off = 12'h010; req_acc = 2'd0;
      @(negedge clk);
      cfg_we = 1'b0; req_valid = 1'b0;
      chk("R9 old cause", rsp_cause, ec);
      chk("R9 old pa", rsp_pa, exp_pa(3, 12'h010));
      m_base[3] = 16'h4000; m_limit[3] = 13'h008; m_valid[3] = 1'b1; m_perm[3] = 3'b111;
      send(3, 12'h010, 0, "R9 new limit");
      send(3, 12'h007, 0, "R9 new base");

      // R2: back to back requests, then random mix
      for (int n = 0; n < 600; n++) begin
         int r;
         r = $urandom_range(0, 9);
         if (r == 0) begin
            set_len($urandom_range(0, NSEG));
         end else if (r <= 2) begin
            set_entry($urandom_range(0, NSEG - 1), $urandom_range(0, 16'hFFFF),
                      $urandom_range(0, 1 << OFF_W), ($urandom_range(0, 3) != 0),
                      $urandom_range(0, 7));
         end else begin
            int s, o;
            s = $urandom_range(0, NSEG - 1);
            o = ($urandom_range(0, 1) != 0 && m_limit[s] != 0)
                ? (int'(m_limit[s]) - $urandom_range(0, 1)) & ((1 << OFF_W) - 1)
                : $urandom_range(0, (1 << OFF_W) - 1);
            send(s, o, $urandom_range(0, 3), "R8 random");
         end
      end

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule